// File: doc/BRIEF.md
# Indirect-Access Network Controller Register Bank

This block is the host-facing register bank of a network controller. The host first loads a 2-bit selector through a narrow address port. After that, every access on the 16-bit data port goes to the register that the selector points at. The selector holds its value until the host writes it again, so in normal operation the host leaves it at zero and touches only the command/status word.

The command/status word mixes several kinds of bits:

- Seven event flags, set by pulses from the datapath and cleared by writing 1.
- Two live summary bits built from those flags.
- An interrupt enable that takes the written value on every write.
- Two read-only receiver and transmitter activity bits.
- A transmit-demand bit that only produces a strobe.
- Three run-control bits: stop, start and initialize.

The run-control bits are tracked by a two-state machine. The states are RUN_HALTED (stop bit set, entered at reset) and RUN_ACTIVE. The transition HALTED to ACTIVE happens on a write of start or initialize that does not also write stop. The transition ACTIVE to HALTED happens on any write of stop. Every other write keeps the current state. Each command write also produces a one-cycle strobe toward the datapath.

The other three registers hold configuration: a 24-bit initialization-block address split across two registers, and three bus mode bits.

Top module: `nic_csr_bank`

## Requirements
- R1: The selector resets to 0 and changes only when `rap_we` is high. `rdp_rdata` always shows the selected register: 0 is the command/status word, 1 is the low address, 2 is the high address, 3 is the mode.
- R2: Event input `ev_flags[i]` sets word bit 8+i. Index 6 is babble (bit 14), 5 is heartbeat loss (bit 13), 4 is missed frame (bit 12), 3 is memory error (bit 11), 2 is receive done (bit 10), 1 is transmit done (bit 9) and 0 is init done (bit 8). Writing 1 to one of these bits clears it, and writing 0 leaves it unchanged.
- R3: Bit 15 reads 1 exactly when any of bits 14, 13, 12 or 11 is set.
- R4: Bit 7 reads 1 exactly when any of bits 14, 12, 11, 10, 9 or 8 is set. Bit 13 does not count toward bit 7.
- R5: Bit 6 (interrupt enable) takes the written value on every write to register 0. `irq_o` is high exactly when bits 7 and 6 are both 1.
- R6: Bits 5 (receiver on) and 4 (transmitter on) are ignored by writes. They are set by `rx_on_evt` / `tx_on_evt` only while the machine is in RUN_ACTIVE.
- R7: Writing 1 to bit 3 raises `tx_demand_o` for the one cycle after the write. Bit 3 always reads 0.
- R8: Bit 2 is stop, bit 1 is start and bit 0 is initialize.
  - Writing 1 to a run-control bit sets it; writing 0 to it has no effect.
  - A write of stop clears start, initialize, receiver-on and transmitter-on, and it wins over start or initialize written at the same time.
  - A write of start or initialize without stop clears stop.
  - `stop_o`, `start_o` and `init_o` pulse for the one cycle after the matching accepted write.
- R9: When an event input and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R10: Register 1 stores 16 bits. Register 2 stores only its low 8 bits, and its upper byte reads 0. `init_blk_addr` equals {register 2 low byte, register 1}.
- R11: Register 3 stores bits 2:0, which are also driven on `bus_mode`. Its other bits read 0.
- R12: After reset, register 0 reads 0x0004, registers 1 to 3 read 0, and all strobes and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rap_we | input | 1 | Selector write enable |
| rap_wdata | input | 2 | New selector value |
| rdp_we | input | 1 | Data port write enable |
| rdp_wdata | input | 16 | Data port write value |
| rdp_rdata | output | 16 | Selected register contents |
| ev_flags | input | 7 | Event pulses for the status flags |
| rx_on_evt | input | 1 | Receiver became active |
| tx_on_evt | input | 1 | Transmitter became active |
| irq_o | output | 1 | Interrupt request |
| start_o | output | 1 | Start strobe |
| stop_o | output | 1 | Stop strobe |
| init_o | output | 1 | Initialize strobe |
| tx_demand_o | output | 1 | Transmit-demand strobe |
| init_blk_addr | output | 24 | Initialization block address |
| bus_mode | output | 3 | Bus mode bits |

## Verification
The assertions assume that the data-port write enable is the only path that changes configuration, and that events and writes arrive synchronously as single-cycle levels. Under those assumptions every flag, strobe and state change is visible one edge after its cause.

The stimulus drives all inputs at the falling edge. It lets any event pattern coincide with any write, including writes that clear the same flag or write stop together with start. It biases stop writes to be rare, so that the RUN_ACTIVE state is held for long stretches.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
    localparam int DATA_W = 16;
    localparam int SEL_W  = 2;
    localparam int NFLAG  = 7;

    localparam int B_ERR  = 15;
    localparam int B_FLG  = 8;
    localparam int B_INTR = 7;
    localparam int B_INEA = 6;
    localparam int B_RXON = 5;
    localparam int B_TXON = 4;
    localparam int B_TDMD = 3;
    localparam int B_STOP = 2;
    localparam int B_STRT = 1;
    localparam int B_INIT = 0;

    // flag index: 6 babble, 5 heartbeat, 4 miss, 3 memerr, 2 rx, 1 tx, 0 init done
    localparam logic [NFLAG-1:0] ERR_MASK  = 7'b111_1000;
    localparam logic [NFLAG-1:0] INTR_MASK = 7'b101_1111;

    typedef enum logic [0:0] {RUN_HALTED, RUN_ACTIVE} run_state_e;
    typedef enum logic [SEL_W-1:0] {SEL_CSR, SEL_ADDR_LO, SEL_ADDR_HI, SEL_MODE} reg_sel_e;
endpackage

// File: rtl/nic_csr_status.sv
module nic_csr_status
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NFLAG-1:0]  ev_flags,
    input  logic              rx_up,
    input  logic              tx_up,
    output logic [DATA_W-1:0] csr_val,
    output logic              irq,
    output logic              start_strobe,
    output logic              stop_strobe,
    output logic              init_strobe,
    output logic              tdmd_strobe
);
    logic [NFLAG-1:0] flag_q;
    logic             inea_q, rxon_q, txon_q, strt_q, init_q;
    logic             err_sum, intr_sum;
    logic             stop_wr, go_wr;
    run_state_e       state_q, state_d;

    assign stop_wr = wr_en & wdata[B_STOP];
    assign go_wr   = wr_en & ~wdata[B_STOP] & (wdata[B_STRT] | wdata[B_INIT]);

    // event flags: set wins over write-1 clear
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (ev_flags[i])
                flag_q[i] <= 1'b1;
            else if (wr_en && wdata[B_FLG+i])
                flag_q[i] <= 1'b0;
        end

        p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ev_flags[i] |=> flag_q[i]);
        p_clear_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wdata[B_FLG+i] && !ev_flags[i]) |=> !flag_q[i]);
    end

    // run-control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_HALTED;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALTED: if (go_wr)   state_d = RUN_ACTIVE;
            RUN_ACTIVE: if (stop_wr) state_d = RUN_HALTED;
            default:                 state_d = RUN_HALTED;
        endcase
    end

    // output and control-bit process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inea_q       <= 1'b0;
            rxon_q       <= 1'b0;
            txon_q       <= 1'b0;
            strt_q       <= 1'b0;
            init_q       <= 1'b0;
            start_strobe <= 1'b0;
            stop_strobe  <= 1'b0;
            init_strobe  <= 1'b0;
            tdmd_strobe  <= 1'b0;
        end else begin
            if (wr_en) inea_q <= wdata[B_INEA];
            start_strobe <= go_wr & wdata[B_STRT];
            init_strobe  <= go_wr & wdata[B_INIT];
            stop_strobe  <= stop_wr;
            tdmd_strobe  <= wr_en & wdata[B_TDMD];
            if (stop_wr) begin
                rxon_q <= 1'b0;
                txon_q <= 1'b0;
                strt_q <= 1'b0;
                init_q <= 1'b0;
            end else begin
                if (rx_up && state_q == RUN_ACTIVE) rxon_q <= 1'b1;
                if (tx_up && state_q == RUN_ACTIVE) txon_q <= 1'b1;
                if (go_wr && wdata[B_STRT]) strt_q <= 1'b1;
                if (go_wr && wdata[B_INIT]) init_q <= 1'b1;
            end
        end
    end

    assign err_sum  = |(flag_q & ERR_MASK);
    assign intr_sum = |(flag_q & INTR_MASK);
    assign irq      = intr_sum & inea_q;

    assign csr_val = {err_sum, flag_q, intr_sum, inea_q, rxon_q, txon_q, 1'b0,
                      (state_q == RUN_HALTED), strt_q, init_q};

    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (csr_val[B_STOP] && !strt_q && !init_q && !rxon_q && !txon_q && stop_strobe));
    p_go_leaves_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go_wr |=> (!csr_val[B_STOP] && !stop_strobe));
    p_err_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_flags & ERR_MASK)) |=> csr_val[B_ERR]);
    p_intr_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_flags & INTR_MASK)) |=> csr_val[B_INTR]);
    p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[B_INEA]) |=> !irq);
    p_tdmd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[B_TDMD]) |=> tdmd_strobe);
    p_rxon_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_HALTED && !go_wr) |=> !rxon_q && !txon_q);
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stop_strobe, start_strobe}));
endmodule

// File: rtl/nic_csr_config.sv
module nic_csr_config
    import nic_csr_pkg::*;
#(
    parameter int LO_W   = 16,
    parameter int HI_W   = 8,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_mode,
    input  logic [DATA_W-1:0] wdata,
    output logic [LO_W-1:0]   addr_lo,
    output logic [HI_W-1:0]   addr_hi,
    output logic [MODE_W-1:0] mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lo <= '0;
            addr_hi <= '0;
            mode    <= '0;
        end else begin
            if (wr_lo)   addr_lo <= wdata[LO_W-1:0];
            if (wr_hi)   addr_hi <= wdata[HI_W-1:0];
            if (wr_mode) mode    <= wdata[MODE_W-1:0];
        end
    end

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo || wr_hi) |=> ($stable(addr_lo) && $stable(addr_hi)));
    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode));
    p_mode_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (mode == $past(wdata[MODE_W-1:0])));
endmodule

// File: rtl/nic_csr_bank.sv
module nic_csr_bank
    import nic_csr_pkg::*;
#(
    parameter int LO_W   = 16,
    parameter int HI_W   = 8,
    parameter int MODE_W = 3,
    localparam int ADDR_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rap_we,
    input  logic [SEL_W-1:0]  rap_wdata,
    input  logic              rdp_we,
    input  logic [DATA_W-1:0] rdp_wdata,
    output logic [DATA_W-1:0] rdp_rdata,
    input  logic [NFLAG-1:0]  ev_flags,
    input  logic              rx_on_evt,
    input  logic              tx_on_evt,
    output logic              irq_o,
    output logic              start_o,
    output logic              stop_o,
    output logic              init_o,
    output logic              tx_demand_o,
    output logic [ADDR_W-1:0] init_blk_addr,
    output logic [MODE_W-1:0] bus_mode
);
    reg_sel_e          sel_q;
    logic [DATA_W-1:0] csr_val;
    logic [LO_W-1:0]   addr_lo;
    logic [HI_W-1:0]   addr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= SEL_CSR;
        else if (rap_we) sel_q <= reg_sel_e'(rap_wdata);
    end

    nic_csr_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (rdp_we && sel_q == SEL_CSR),
        .wdata        (rdp_wdata),
        .ev_flags     (ev_flags),
        .rx_up        (rx_on_evt),
        .tx_up        (tx_on_evt),
        .csr_val      (csr_val),
        .irq          (irq_o),
        .start_strobe (start_o),
        .stop_strobe  (stop_o),
        .init_strobe  (init_o),
        .tdmd_strobe  (tx_demand_o)
    );

    nic_csr_config #(.LO_W(LO_W), .HI_W(HI_W), .MODE_W(MODE_W)) u_config (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (rdp_we && sel_q == SEL_ADDR_LO),
        .wr_hi   (rdp_we && sel_q == SEL_ADDR_HI),
        .wr_mode (rdp_we && sel_q == SEL_MODE),
        .wdata   (rdp_wdata),
        .addr_lo (addr_lo),
        .addr_hi (addr_hi),
        .mode    (bus_mode)
    );

    assign init_blk_addr = {addr_hi, addr_lo};

    always_comb begin
        rdp_rdata = '0;
        unique case (sel_q)
            SEL_CSR:     rdp_rdata = csr_val;
            SEL_ADDR_LO: rdp_rdata = DATA_W'(addr_lo);
            SEL_ADDR_HI: rdp_rdata = DATA_W'(addr_hi);
            SEL_MODE:    rdp_rdata = DATA_W'(bus_mode);
            default:     rdp_rdata = '0;
        endcase
    end

    p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rap_we |=> $stable(sel_q));
    p_sel_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rap_we |=> (sel_q == $past(rap_wdata)));
endmodule

// File: tb/tb_nic_csr_bank.sv
module tb_nic_csr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rap_we = 1'b0;
    logic [1:0]  rap_wdata = '0;
    logic        rdp_we = 1'b0;
    logic [15:0] rdp_wdata = '0;
    logic [15:0] rdp_rdata;
    logic [6:0]  ev_flags = '0;
    logic        rx_on_evt = 1'b0, tx_on_evt = 1'b0;
    logic        irq_o, start_o, stop_o, init_o, tx_demand_o;
    logic [23:0] init_blk_addr;
    logic [2:0]  bus_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [6:0] m_flag;
    logic m_inea, m_rx, m_tx, m_stop, m_strt, m_init;
    logic m_sp, m_tp, m_ip, m_dp;

    always #10 clk = ~clk;

    nic_csr_bank dut (
        .clk(clk), .rst_n(rst_n), .rap_we(rap_we), .rap_wdata(rap_wdata),
        .rdp_we(rdp_we), .rdp_wdata(rdp_wdata), .rdp_rdata(rdp_rdata),
        .ev_flags(ev_flags), .rx_on_evt(rx_on_evt), .tx_on_evt(tx_on_evt),
        .irq_o(irq_o), .start_o(start_o), .stop_o(stop_o), .init_o(init_o),
        .tx_demand_o(tx_demand_o), .init_blk_addr(init_blk_addr), .bus_mode(bus_mode)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_sel(logic [1:0] s);
        rap_we = 1'b1; rap_wdata = s;
        @(negedge clk);
        rap_we = 1'b0;
    endtask

    // one cycle of stimulus, returns at the next falling edge
    task automatic step(logic we, logic [15:0] wd, logic [6:0] ev, logic rxu, logic txu);
        rdp_we = we; rdp_wdata = wd; ev_flags = ev; rx_on_evt = rxu; tx_on_evt = txu;
        @(negedge clk);
        rdp_we = 1'b0; ev_flags = '0; rx_on_evt = 1'b0; tx_on_evt = 1'b0;
    endtask

    function automatic logic [15:0] exp_word();
        logic err, intr;
        err  = |m_flag[6:3];
        intr = m_flag[6] | (|m_flag[4:0]);
        return {err, m_flag, intr, m_inea, m_rx, m_tx, 1'b0, m_stop, m_strt, m_init};
    endfunction

    function automatic void model_reset();
        m_flag = '0; m_inea = 0; m_rx = 0; m_tx = 0; m_stop = 1; m_strt = 0; m_init = 0;
        m_sp = 0; m_tp = 0; m_ip = 0; m_dp = 0;
    endfunction

    function automatic void model_step(logic we, logic [15:0] wd, logic [6:0] ev, logic rxu, logic txu);
        logic sw, gw, running;
        sw = we & wd[2];
        gw = we & ~wd[2] & (wd[1] | wd[0]);
        running = ~m_stop;
        m_flag = ev | (m_flag & ~(we ? wd[14:8] : 7'h0));
        if (we) m_inea = wd[6];
        m_sp = sw; m_tp = gw & wd[1]; m_ip = gw & wd[0]; m_dp = we & wd[3];
        if (sw) begin
            m_rx = 0; m_tx = 0; m_strt = 0; m_init = 0; m_stop = 1;
        end else begin
            if (rxu & running) m_rx = 1;
            if (txu & running) m_tx = 1;
            if (gw & wd[1]) m_strt = 1;
            if (gw & wd[0]) m_init = 1;
            if (gw) m_stop = 0;
        end
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        @(negedge clk);
        do_reset();

        // R12 reset values
        chk("R12 csr0", rdp_rdata, 16'h0004);
        chk("R12 strobes/irq", {irq_o, start_o, stop_o, init_o, tx_demand_o}, 5'b0);
        chk("R12 addr/mode", {init_blk_addr, bus_mode}, 27'h0);

        // R1 R10 R11 configuration registers
        set_sel(2'd1); step(1, 16'hBEEF, 0, 0, 0);
        chk("R10 reg1", rdp_rdata, 16'hBEEF);
        set_sel(2'd2); step(1, 16'hFF5A, 0, 0, 0);
        chk("R10 reg2 upper zero", rdp_rdata, 16'h005A);
        chk("R10 init addr", init_blk_addr, 24'h5ABEEF);
        set_sel(2'd3); step(1, 16'hFFFF, 0, 0, 0);
        chk("R11 reg3", rdp_rdata, 16'h0007);
        chk("R11 bus_mode", bus_mode, 3'd7);
        set_sel(2'd1);
        chk("R1 reselect reg1", rdp_rdata, 16'hBEEF);
        set_sel(2'd0);
        chk("R1 reselect csr0", rdp_rdata, 16'h0004);

        // R2 R3 R4 R5 flags and summaries
        step(0, 0, 7'b010_0000, 0, 0);
        chk("R3 R4 heartbeat sets err only", rdp_rdata, 16'hA004);
        step(0, 0, 7'b000_0100, 0, 0);
        chk("R4 rx done sets intr", rdp_rdata, 16'hA484);
        chk("R5 irq off", irq_o, 1'b0);
        step(1, 16'h0040, 0, 0, 0);
        chk("R5 enable", rdp_rdata, 16'hA4C4);
        chk("R5 irq on", irq_o, 1'b1);
        step(1, 16'h2000, 0, 0, 0);
        chk("R2 R3 R5 clear heartbeat, enable dropped", rdp_rdata, 16'h0484);
        chk("R5 irq dropped", irq_o, 1'b0);
        step(1, 16'h0400, 0, 0, 0);
        chk("R2 clear rx done", rdp_rdata, 16'h0004);
        step(0, 0, 7'b000_0010, 0, 0);
        step(1, 16'h0000, 0, 0, 0);
        chk("R2 write zero keeps flag", rdp_rdata, 16'h0284);
        step(1, 16'h4200, 7'b100_0000, 0, 0);
        chk("R9 event beats clear", rdp_rdata, 16'hC084);
        step(1, 16'h4000, 0, 0, 0);
        chk("R2 clear babble", rdp_rdata, 16'h0004);

        // R6 R7 R8 run control
        step(1, 16'h0030, 0, 1, 1);
        chk("R6 halted ignores on bits", rdp_rdata, 16'h0004);
        step(1, 16'h0002, 0, 0, 0);
        chk("R8 start", rdp_rdata, 16'h0002);
        chk("R8 start strobe", {start_o, stop_o, init_o}, 3'b100);
        step(0, 0, 0, 1, 1);
        chk("R6 on bits set", rdp_rdata, 16'h0032);
        step(1, 16'h0008, 0, 0, 0);
        chk("R7 tdmd strobe", tx_demand_o, 1'b1);
        chk("R7 tdmd reads zero", rdp_rdata, 16'h0032);
        step(1, 16'h0001, 0, 0, 0);
        chk("R8 init", rdp_rdata, 16'h0033);
        chk("R8 init strobe", {start_o, stop_o, init_o}, 3'b001);
        step(1, 16'h0006, 0, 0, 0);
        chk("R8 stop wins", rdp_rdata, 16'h0004);
        chk("R8 stop strobe only", {start_o, stop_o, init_o}, 3'b010);
        step(0, 0, 0, 1, 0);
        chk("R6 no rx on while halted", rdp_rdata, 16'h0004);

        // random phase against the model
        do_reset();
        model_reset();
        for (int n = 0; n < 3000; n++) begin
            logic we, rxu, txu;
            logic [15:0] wd;
            logic [6:0] ev;
            we  = ($urandom % 3) == 0;
            wd  = 16'($urandom);
            if (($urandom % 5) != 0) wd[2] = 1'b0;
            if (($urandom % 2) != 0) wd[14:8] = 7'h0;
            ev  = (($urandom % 3) == 0) ? 7'($urandom) : 7'h0;
            rxu = ($urandom % 6) == 0;
            txu = ($urandom % 6) == 0;
            step(we, wd, ev, rxu, txu);
            model_step(we, wd, ev, rxu, txu);
            chk("R2 R3 R4 R6 R8 R9 word", rdp_rdata, exp_word());
            chk("R5 R7 R8 strobes", {irq_o, start_o, stop_o, init_o, tx_demand_o},
                {m_inea & (m_flag[6] | (|m_flag[4:0])), m_tp, m_sp, m_ip, m_dp});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule